// File: doc/BRIEF.md
# Marker-Terminated Radio Frame Capture

This block sits behind a line decoder that has already recovered data bits from a radio signal. It takes one bit per strobe and captures a frame that consists of a fixed 96-bit preamble followed by a 96-bit payload. Both phases share a single shift register, because the two halves of the frame have the same length.

While it searches, the register holds the most recent 96 bits and is compared against a preamble pattern set by a parameter. On a match the register is reloaded with a single set marker bit, and payload bits are shifted in behind it. When the marker has been pushed past the last payload position, the register freezes and `full` rises. It stays frozen until reset.

The captured payload is read out one byte at a time through a 4-bit address, using a combinational multiplexer. A `hold` input pauses shifting at any time without clearing anything.

Top module: `sentinel_frame_capture`

## Requirements
- R1: After reset `full` and `frame_start` are 0, and every address reads 0x00.
- R2: A bit is taken only in a cycle with `bit_valid` high, and it enters at position 0, so position 0 always holds the newest accepted bit. Cycles with `bit_valid` low change nothing.
- R3: While searching, when the 96 most recently accepted bits equal the `PREAMBLE` parameter, the register is reloaded with the value 1 (the marker) instead of shifting. `frame_start` is high for exactly the one cycle after that accepting edge. In the default pattern, register bit i is 1 when i is odd, so the first bit of the preamble on the air is 1 and the bits alternate from there.
- R4: `full` rises on the edge that accepts the 96th payload bit after the reload.
- R5: Once `full` is high, it stays high and further strobes leave the contents unchanged until reset.
- R6: While `hold` is high, strobes are ignored in every phase. A held strobe does not count toward preamble detection.
- R7: Address k, for k from 0 to 11, reads payload bits 8k+7 down to 8k. Payload bit 0 is the last payload bit received. IDs occupy addresses 0 to 3 from the low byte up, room temperature 4 to 5, set temperature 6 to 7, state 8, and tail bytes 9 to 11.
- R8: Addresses 12 to 15 always read 0x00.
- R9: Reset returns the block to preamble search with the register cleared, even after a completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a decoded bit this cycle |
| bit_in | input | 1 | Decoded data bit |
| hold | input | 1 | Pause: strobes are ignored while high |
| addr | input | 4 | Byte select for readout |
| rd_data | output | 8 | Selected byte (combinational) |
| full | output | 1 | Payload captured; register frozen |
| frame_start | output | 1 | One-cycle pulse when the preamble is recognised |

## Verification
A wrong register state is visible at `rd_data` during the very next cycle for whichever byte is addressed. The bench compares the addressed byte against a behavioural model on every clock, and it sweeps addresses at the end of each frame. A wrong phase shows up in different ways depending on the error. If the preamble is missed, `frame_start` never pulses. If the preamble is matched too early, the readout shows 0x01 in byte 0 a cycle before the model expects it. If the marker is tracked incorrectly, `full` rises one strobe early or late, or it lets a post-full strobe alter the bytes on the following cycle.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef enum logic [1:0] {
    PH_SEARCH  = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_DONE    = 2'd2
  } phase_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/fcap_match.sv
module fcap_match #(
  parameter int                    FRAME_BITS = 96,
  parameter logic [FRAME_BITS-1:0] PREAMBLE   = {(FRAME_BITS/2){2'b10}}
) (
  input  logic [FRAME_BITS-1:0] cand,
  output logic                  hit
);
  function automatic logic pattern_equal(input logic [FRAME_BITS-1:0] a,
                                         input logic [FRAME_BITS-1:0] b);
    return (a ^ b) == '0;
  endfunction

  assign hit = pattern_equal(cand, PREAMBLE);
endmodule

// File: rtl/fcap_ctrl.sv
module fcap_ctrl
  import fcap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_valid,
  input  logic   hold,
  input  logic   hit,
  input  logic   marker_next,
  output logic   do_shift,
  output logic   do_reload,
  output logic   clear_top,
  output logic   full,
  output logic   frame_start,
  output phase_t phase
);
  phase_t phase_d;
  logic   accept;

  assign accept    = bit_valid && !hold && (phase != PH_DONE);
  assign do_reload = accept && (phase == PH_SEARCH) && hit;
  assign do_shift  = accept && !do_reload;
  assign clear_top = (phase == PH_SEARCH);
  assign full      = (phase == PH_DONE);

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_SEARCH:  if (do_reload) phase_d = PH_CAPTURE;
      PH_CAPTURE: if (accept && marker_next) phase_d = PH_DONE;
      default:    phase_d = phase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_SEARCH;
      frame_start <= 1'b0;
    end else begin
      phase       <= phase_d;
      frame_start <= do_reload;
    end
  end

  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
  p_start_leads_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> phase == PH_CAPTURE);
endmodule

// File: rtl/fcap_shreg.sv
module fcap_shreg #(
  parameter int FRAME_BITS = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_shift,
  input  logic              do_reload,
  input  logic              clear_top,
  input  logic              bit_in,
  output logic [FRAME_BITS:0] sr
);
  localparam logic [FRAME_BITS:0] MARKER = {{FRAME_BITS{1'b0}}, 1'b1};

  function automatic logic [FRAME_BITS:0] shift_once(input logic [FRAME_BITS:0] v,
                                                     input logic mask_top,
                                                     input logic b);
    logic [FRAME_BITS:0] r;
    r = {v[FRAME_BITS-1:0], b};
    if (mask_top) r[FRAME_BITS] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         sr <= '0;
    else if (do_reload) sr <= MARKER;
    else if (do_shift)  sr <= shift_once(sr, clear_top, bit_in);
  end

  p_reload_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_reload |=> sr == MARKER);
  p_newest_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_shift && !do_reload) |=> sr[0] == $past(bit_in));
endmodule

// File: rtl/fcap_rdmux.sv
module fcap_rdmux
  import fcap_pkg::*;
#(
  parameter int FRAME_BITS = 96,
  parameter int ADDR_W     = 4
) (
  input  logic [FRAME_BITS-1:0] payload,
  input  logic [ADDR_W-1:0]     addr,
  output logic [BYTE_W-1:0]     rd_data
);
  localparam int NLANE = FRAME_BITS / BYTE_W;
  localparam int NSLOT = 1 << ADDR_W;

  logic [BYTE_W-1:0] lane [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_lane
    if (k < NLANE) begin : g_data
      assign lane[k] = payload[k*BYTE_W +: BYTE_W];
    end else begin : g_zero
      assign lane[k] = '0;
    end
  end

  assign rd_data = lane[addr];
endmodule

// File: rtl/sentinel_frame_capture.sv
module sentinel_frame_capture
  import fcap_pkg::*;
#(
  parameter int                    FRAME_BITS = 96,
  parameter int                    ADDR_W     = 4,
  parameter logic [FRAME_BITS-1:0] PREAMBLE   = {(FRAME_BITS/2){2'b10}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rd_data,
  output logic              full,
  output logic              frame_start
);
  localparam int NLANE = FRAME_BITS / BYTE_W;

  logic [FRAME_BITS:0]   sr;
  logic [FRAME_BITS-1:0] cand;
  logic                  hit, do_shift, do_reload, clear_top;
  phase_t                phase;

  assign cand = {sr[FRAME_BITS-2:0], bit_in};

  fcap_match #(.FRAME_BITS(FRAME_BITS), .PREAMBLE(PREAMBLE)) u_match (
    .cand(cand), .hit(hit)
  );

  fcap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .hold(hold),
    .hit(hit), .marker_next(sr[FRAME_BITS-1]),
    .do_shift(do_shift), .do_reload(do_reload), .clear_top(clear_top),
    .full(full), .frame_start(frame_start), .phase(phase)
  );

  fcap_shreg #(.FRAME_BITS(FRAME_BITS)) u_shreg (
    .clk(clk), .rst_n(rst_n), .do_shift(do_shift), .do_reload(do_reload),
    .clear_top(clear_top), .bit_in(bit_in), .sr(sr)
  );

  fcap_rdmux #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W)) u_rdmux (
    .payload(sr[FRAME_BITS-1:0]), .addr(addr), .rd_data(rd_data)
  );

  p_freeze_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(sr));
  p_hold_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(sr) && $stable(phase)));
  p_marker_means_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr[FRAME_BITS] |-> full);
  p_idle_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(sr));
  p_high_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= NLANE) |-> rd_data == 8'h00);
endmodule

// File: tb/sentinel_frame_capture_bench.sv
module sentinel_frame_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       hold = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] rd_data;
  logic       full, frame_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sentinel_frame_capture u_sentinel_frame_capture (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .hold(hold), .addr(addr), .rd_data(rd_data), .full(full),
    .frame_start(frame_start)
  );

  // behavioural reference
  bit hist[$];
  bit pay[$];
  bit m_search = 1;
  bit m_full = 0;
  bit m_start = 0;

  function automatic bit pre_ok();
    if (hist.size() != 96) return 0;
    for (int j = 0; j < 96; j++) if (hist[j] != (j % 2 == 0)) return 0;
    return 1;
  endfunction

  function automatic bit ref_bit(int i);
    if (m_search) return (i < hist.size()) ? hist[hist.size()-1-i] : 1'b0;
    if (i < pay.size()) return pay[pay.size()-1-i];
    return (i == pay.size());
  endfunction

  function automatic int ref_byte(int a);
    int v = 0;
    if (a >= 12) return 0;
    for (int k = 0; k < 8; k++) v |= int'(ref_bit(8*a + k)) << k;
    return v;
  endfunction

  always @(posedge clk) begin
    m_start <= 0;
    if (!rst_n) begin
      hist.delete(); pay.delete(); m_search = 1; m_full = 0;
    end else if (bit_valid && !hold && !m_full) begin
      if (m_search) begin
        hist.push_back(bit_in);
        if (hist.size() > 96) void'(hist.pop_front());
        if (pre_ok()) begin
          m_search = 0; pay.delete(); m_start <= 1;
        end
      end else begin
        pay.push_back(bit_in);
        if (pay.size() == 96) m_full = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) begin
    cyc++;
    if (compare_on && rst_n) begin
      chk(full == m_full, "R4 full vs model", full, m_full);
      chk(frame_start == m_start, "R3 frame_start vs model", frame_start, m_start);
      chk(rd_data == ref_byte(addr), "R7 rd_data vs model", rd_data, ref_byte(addr));
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send_bit(input bit b, input int gap);
    @(negedge clk); bit_valid = 1; bit_in = b;
    @(negedge clk); bit_valid = 0; bit_in = ~b;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_preamble();
    for (int j = 0; j < 96; j++) send_bit(j % 2 == 0, 0);
  endtask

  byte pv[12] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'h5A, 8'hC3, 8'h3C,
                  8'h07, 8'hF0, 8'h81, 8'h7E};

  task automatic send_payload(input int stop_at);
    for (int i = 95; i >= stop_at; i--) send_bit(pv[i/8][i%8], i % 3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk(full == 0, "R1 full after reset", full, 0);
    chk(frame_start == 0, "R1 frame_start after reset", frame_start, 0);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); #1;
      chk(rd_data == 0, "R1 readout after reset", rd_data, 0);
    end
    addr = 0;
    compare_on = 1;

    // R2: newest bit at position 0
    for (int k = 7; k >= 0; k--) send_bit(8'hB6 >> k, 1);
    chk(rd_data == 8'hB6, "R2 byte0 after 8 bits", rd_data, 8'hB6);
    repeat (5) begin @(negedge clk); bit_in = ~bit_in; end
    chk(rd_data == 8'hB6, "R2 no change without strobe", rd_data, 8'hB6);

    // R6: hold in search
    hold = 1;
    for (int k = 0; k < 6; k++) send_bit(k[0], 0);
    chk(rd_data == 8'hB6, "R6 held strobes ignored", rd_data, 8'hB6);
    hold = 0;

    // R3: broken preamble then true preamble
    for (int j = 0; j < 60; j++) send_bit(j % 2 == 0, 0);
    send_bit(1, 0); send_bit(1, 0);
    chk(frame_start == 0, "R3 no start on broken pattern", frame_start, 0);
    // a held preamble bit must not count
    for (int j = 0; j < 95; j++) send_bit(j % 2 == 0, 0);
    hold = 1; send_bit(0, 0); hold = 0;
    chk(frame_start == 0, "R6 held bit not counted", frame_start, 0);
    send_bit(0, 0);
    chk(frame_start == 1, "R3 start pulse", frame_start, 1);
    chk(rd_data == 8'h01, "R3 marker after reload", rd_data, 1);
    @(negedge clk);
    chk(frame_start == 0, "R3 start lasts one cycle", frame_start, 0);

    // R4: payload capture
    send_payload(1);
    chk(full == 0, "R4 not full after 95 bits", full, 0);
    hold = 1; send_bit(1, 0); hold = 0;
    chk(full == 0, "R6 hold in capture", full, 0);
    send_bit(pv[0][0], 0);
    chk(full == 1, "R4 full after 96 bits", full, 1);

    // R7 / R8 readout sweep
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); #1;
      if (a < 12) chk(rd_data == pv[a], "R7 payload byte", rd_data, pv[a]);
      else        chk(rd_data == 0, "R8 high address zero", rd_data, 0);
    end

    // R5: frozen after full
    addr = 4'd5;
    for (int k = 0; k < 10; k++) send_bit(k[1], 0);
    chk(full == 1, "R5 full sticky", full, 1);
    chk(rd_data == pv[5], "R5 contents frozen", rd_data, pv[5]);

    // R9: reset returns to search with cleared register
    compare_on = 0;
    do_reset();
    compare_on = 1;
    chk(full == 0, "R9 full cleared", full, 0);
    chk(rd_data == 0, "R9 register cleared", rd_data, 0);
    send_preamble();
    chk(frame_start == 1, "R9 second frame detected", frame_start, 1);
    send_payload(0);
    chk(full == 1, "R9 second frame full", full, 1);
    addr = 4'd8; #1;
    chk(rd_data == pv[8], "R7 state byte second frame", rd_data, pv[8]);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule